// File: doc/BRIEF.md
# Pairwise Discrepancy Fitness Tracker

This block watches one pair of redundant circuits that compute the same function on the same live data. On every valid sample it compares the two result words and counts the samples on which they disagree. No test vectors are injected. After a fixed number of valid samples it closes the evaluation window. It then moves each circuit of the pair through a four-state health machine, using the disagreement total of the window that just closed.

The agreement signal comes from two equality checkers, one per side. Each checker compares its own side's result with the other side's result. Their verdicts are merged as an open-drain style wired AND. The merged match bit is 1 only when both results agree and neither checker reports a difference, so a fault in either checker also shows up as a discrepancy.

When a circuit is sent to repair, the block raises a one-cycle repair request. It then freezes evaluation until the external repair logic returns a completion pulse. Only one side may be in repair at a time.

Top module: `pair_fitness_tracker`

## Requirements
- R1: After reset both sides are in state HEALTHY (code 0), the discrepancy count is 0 and the repair request is low.
- R2: Only cycles with `valid_i` high count as samples. A window closes on the 600th valid sample, and the count of that sample is included. At that edge the count returns to 0. Mid-window, `disc_cnt_o` equals the number of disagreeing valid samples so far, and cycles without `valid_i` change nothing.
- R3: At a window close, a side in HEALTHY (0) or RESTORED (3) moves to DOUBTED (1) when the total exceeds 6. Otherwise it stays where it is.
- R4: At a window close, a side in DOUBTED (1) moves to MENDING (2) when the total exceeds 6, if the repair slot is free. With a total of 6 or less it returns to HEALTHY (0).
- R5: At a window close, a side in MENDING (2) moves to RESTORED (3) when the total is 4 or less. Otherwise it stays in MENDING and is sent to repair again.
- R6: Every window close that sends a side to repair, or keeps it there, raises `fix_req_o` for exactly one cycle, starting at that edge. The block then enters a hold phase. In the hold phase valid samples are not counted and states do not change, until a `fix_done_i` pulse starts a fresh window.
- R7: At most one side is in MENDING at any time. When both sides qualify in the same window, side A takes the slot and side B stays DOUBTED.
- R8: `match_o` is 1 when the two result words are equal and 0 when they differ. It is formed as the AND of the two per-side checker verdicts.
- R9: A `fix_done_i` pulse outside the hold phase has no effect. This includes a pulse that coincides with the sample that closes a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_a_i | input | W | Result word of side A |
| res_b_i | input | W | Result word of side B |
| valid_i | input | 1 | The result words form a sample this cycle |
| fix_done_i | input | 1 | Pulse from the repair logic: repair finished |
| state_a_o | output | 2 | Health state of side A (0 HEALTHY, 1 DOUBTED, 2 MENDING, 3 RESTORED) |
| state_b_o | output | 2 | Health state of side B, same encoding |
| disc_cnt_o | output | $clog2(WIN+1) | Disagreeing valid samples in the current window |
| fix_req_o | output | 1 | One-cycle repair request |
| match_o | output | 1 | Merged agreement verdict of the two checkers |

## Verification
Two events can share one clock edge: the valid sample that closes a window, and a repair-completion pulse. The bench drives `fix_done_i` high together with the 600th sample of a window that sends side A to repair. It then expects the request pulse and the hold phase anyway. While holding, it feeds twenty disagreeing valid samples and expects the count and states unchanged. Only a later, separate completion pulse restarts counting.

// File: rtl/pft_pkg.sv
package pft_pkg;

    typedef enum logic [1:0] {
        FIT_HEALTHY  = 2'd0,
        FIT_DOUBTED  = 2'd1,
        FIT_MENDING  = 2'd2,
        FIT_RESTORED = 2'd3
    } fit_e;

    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_HOLD = 1'b1
    } mode_e;

endpackage

// File: rtl/pft_eq_checker.sv
module pft_eq_checker #(
    parameter int W = 8
) (
    input  logic [W-1:0] mine_i,
    input  logic [W-1:0] other_i,
    output logic         ok_o
);
    // One side's own verdict: its result against the partner's result.
    always_comb begin
        ok_o = (mine_i == other_i);
    end
endmodule

// File: rtl/pft_window.sv
module pft_window #(
    parameter int WIN = 600,
    localparam int CW = $clog2(WIN + 1),
    localparam int IW = $clog2(WIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          count_en_i,
    input  logic          mism_i,
    output logic          close_o,
    output logic [CW-1:0] total_o,
    output logic [CW-1:0] cnt_o
);
    logic [IW-1:0] idx_q;
    logic [CW-1:0] cnt_q;

    always_comb begin
        close_o = count_en_i && (idx_q == IW'(WIN - 1));
        total_o = cnt_q + CW'(mism_i);
        cnt_o   = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            cnt_q <= '0;
        end else if (count_en_i) begin
            if (close_o) begin
                idx_q <= '0;
                cnt_q <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
                if (mism_i && (cnt_q != CW'(WIN))) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R2: mismatches can never outnumber the samples already taken
    a_r2_cnt_within_samples: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(cnt_q) <= 32'(idx_q)));

    // R2: the count is cleared once the closing sample has been taken
    a_r2_clear_on_close: assert property (@(posedge clk) disable iff (!rst_n)
        close_o |=> (cnt_q == '0));
endmodule

// File: rtl/pft_side_fsm.sv
module pft_side_fsm
    import pft_pkg::*;
#(
    parameter int CW = 10,
    parameter int DOUBT_LIM = 6,
    parameter int MEND_LIM = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          close_i,
    input  logic [CW-1:0] total_i,
    input  logic          may_mend_i,
    output fit_e          state_o,
    output logic          go_mend_o
);
    fit_e state_q, state_n;
    logic over_doubt, within_mend;

    always_comb begin
        over_doubt  = (32'(total_i) > DOUBT_LIM);
        within_mend = (32'(total_i) <= MEND_LIM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FIT_HEALTHY;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n   = state_q;
        go_mend_o = 1'b0;
        if (close_i) begin
            unique case (state_q)
                FIT_HEALTHY: if (over_doubt) state_n = FIT_DOUBTED;
                FIT_DOUBTED: begin
                    if (!over_doubt) begin
                        state_n = FIT_HEALTHY;
                    end else if (may_mend_i) begin
                        state_n   = FIT_MENDING;
                        go_mend_o = 1'b1;
                    end
                end
                FIT_MENDING: begin
                    if (within_mend) state_n = FIT_RESTORED;
                    else             go_mend_o = 1'b1;
                end
                FIT_RESTORED: if (over_doubt) state_n = FIT_DOUBTED;
                default: state_n = FIT_HEALTHY;
            endcase
        end
        state_o = state_q;
    end

    // R3: a healthy side can only stay healthy or fall to doubted
    a_r3_healthy_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FIT_HEALTHY) |=> (state_q == FIT_HEALTHY || state_q == FIT_DOUBTED));

    // R5: a side in repair can only stay there or become restored
    a_r5_mending_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FIT_MENDING) |=> (state_q == FIT_MENDING || state_q == FIT_RESTORED));

    // R3: states move only at a window close
    a_r3_move_on_close: assert property (@(posedge clk) disable iff (!rst_n)
        !close_i |=> $stable(state_q));
endmodule

// File: rtl/pair_fitness_tracker.sv
module pair_fitness_tracker
    import pft_pkg::*;
#(
    parameter int W = 8,
    parameter int WIN = 600,
    parameter int DOUBT_LIM = 6,
    parameter int MEND_LIM = 4,
    localparam int CW = $clog2(WIN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  res_a_i,
    input  logic [W-1:0]  res_b_i,
    input  logic          valid_i,
    input  logic          fix_done_i,
    output logic [1:0]    state_a_o,
    output logic [1:0]    state_b_o,
    output logic [CW-1:0] disc_cnt_o,
    output logic          fix_req_o,
    output logic          match_o
);
    localparam int SIDES = 2;

    logic [W-1:0]  res_pair [SIDES];
    logic [SIDES-1:0] chk_ok;
    fit_e          st [SIDES];
    logic [SIDES-1:0] go_mend;
    logic [SIDES-1:0] may_mend;
    mode_e         mode_q, mode_n;
    logic          req_q, req_n;
    logic          count_en, win_close;
    logic [CW-1:0] win_total, win_cnt;

    assign res_pair[0] = res_a_i;
    assign res_pair[1] = res_b_i;

    // Duplicated checkers; verdicts merged like an open-drain wire.
    for (genvar g = 0; g < SIDES; g++) begin : g_chk
        pft_eq_checker #(.W(W)) i_chk (
            .mine_i (res_pair[g]),
            .other_i(res_pair[SIDES-1-g]),
            .ok_o   (chk_ok[g])
        );
    end
    assign match_o = &chk_ok;

    assign count_en = valid_i && (mode_q == MODE_RUN);

    pft_window #(.WIN(WIN)) i_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_en_i(count_en),
        .mism_i    (!match_o),
        .close_o   (win_close),
        .total_o   (win_total),
        .cnt_o     (win_cnt)
    );

    // Single repair slot, side A first.
    always_comb begin
        may_mend[0] = (st[1] != FIT_MENDING);
        may_mend[1] = (st[0] != FIT_MENDING) && !go_mend[0];
    end

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        pft_side_fsm #(
            .CW(CW), .DOUBT_LIM(DOUBT_LIM), .MEND_LIM(MEND_LIM)
        ) i_side (
            .clk       (clk),
            .rst_n     (rst_n),
            .close_i   (win_close),
            .total_i   (win_total),
            .may_mend_i(may_mend[g]),
            .state_o   (st[g]),
            .go_mend_o (go_mend[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_RUN;
            req_q  <= 1'b0;
        end else begin
            mode_q <= mode_n;
            req_q  <= req_n;
        end
    end

    always_comb begin
        mode_n = mode_q;
        req_n  = 1'b0;
        unique case (mode_q)
            MODE_RUN: begin
                if (win_close && (|go_mend)) begin
                    mode_n = MODE_HOLD;
                    req_n  = 1'b1;
                end
            end
            MODE_HOLD: if (fix_done_i) mode_n = MODE_RUN;
            default: mode_n = MODE_RUN;
        endcase
    end

    always_comb begin
        state_a_o  = st[0];
        state_b_o  = st[1];
        disc_cnt_o = win_cnt;
        fix_req_o  = req_q;
    end

    // R6: the repair request never lasts two cycles
    a_r6_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        fix_req_o |=> !fix_req_o);

    // R6: the hold phase freezes states and count until repair completes
    a_r6_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_HOLD && !fix_done_i) |=> ($stable(st[0]) && $stable(st[1]) && disc_cnt_o == '0));

    // R7: never both sides in repair
    a_r7_one_mending: assert property (@(posedge clk) disable iff (!rst_n)
        !(st[0] == FIT_MENDING && st[1] == FIT_MENDING));

    // R8: differing results always clear the merged verdict
    a_r8_mismatch_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (res_a_i != res_b_i) |-> !match_o);
endmodule

// File: tb/test_pair_fitness_tracker.sv
module test_pair_fitness_tracker;
    localparam int W = 8;
    localparam int WIN = 600;
    localparam int CW = $clog2(WIN + 1);

    typedef struct packed {
        logic [1:0]    sa;
        logic [1:0]    sb;
        logic          req;
        logic [CW-1:0] cnt;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  res_a = '0, res_b = '0;
    logic          valid = 1'b0, fix_done = 1'b0;
    logic [1:0]    state_a, state_b;
    logic [CW-1:0] disc_cnt;
    logic          fix_req, match;

    int   n_checks = 0;
    int   n_errors = 0;
    exp_t exp_q[$];
    string tag_q[$];
    logic [1:0] ea = 2'd0, eb = 2'd0;

    always #10 clk = ~clk;   // 50 MHz

    pair_fitness_tracker #(.W(W), .WIN(WIN)) i_pair_fitness_tracker (
        .clk(clk), .rst_n(rst_n), .res_a_i(res_a), .res_b_i(res_b),
        .valid_i(valid), .fix_done_i(fix_done), .state_a_o(state_a),
        .state_b_o(state_b), .disc_cnt_o(disc_cnt), .fix_req_o(fix_req),
        .match_o(match)
    );

    task automatic push(input logic rq, input int cnt, input string tg);
        exp_t e;
        e.sa = ea; e.sb = eb; e.req = rq; e.cnt = CW'(cnt);
        exp_q.push_back(e);
        tag_q.push_back(tg);
    endtask

    // Monitor: compares one queued expectation per falling edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t  e;
            string tg;
            e  = exp_q.pop_front();
            tg = tag_q.pop_front();
            n_checks++;
            if (state_a !== e.sa || state_b !== e.sb || fix_req !== e.req || disc_cnt !== e.cnt) begin
                n_errors++;
                $display("FAIL %s: got a=%0d b=%0d req=%0d cnt=%0d, expected a=%0d b=%0d req=%0d cnt=%0d",
                         tg, state_a, state_b, fix_req, disc_cnt, e.sa, e.sb, e.req, e.cnt);
            end
        end
    end

    task automatic direct_check(input logic got, input logic want, input string tg);
        n_checks++;
        if (got !== want) begin
            n_errors++;
            $display("FAIL %s: got %0d expected %0d", tg, got, want);
        end
    endtask

    // Driver: one full window with n_mis disagreeing samples at its start.
    task automatic run_window(input int n_mis, input logic [1:0] na, input logic [1:0] nb,
                              input logic rq, input logic done_at_close, input string tg);
        for (int i = 0; i < WIN; i++) begin
            if (i == 5) begin
                @(negedge clk);
                valid = 1'b0; res_a = 8'h3C; res_b = 8'hC3;   // ignored, R2
            end
            @(negedge clk);
            valid = 1'b1;
            res_a = W'(i * 7);
            res_b = (i < n_mis) ? (W'(i * 7) ^ 8'h01) : W'(i * 7);
            fix_done = (i == WIN - 1) ? done_at_close : 1'b0;
            @(posedge clk);
            if (i == 9) push(1'b0, (n_mis < 10) ? n_mis : 10, "R2 mid-window count");
            if (i == WIN - 1) begin
                ea = na; eb = nb;
                push(rq, 0, tg);
            end
        end
        @(negedge clk);
        valid = 1'b0; fix_done = 1'b0;
        @(posedge clk);
        push(1'b0, 0, "R6 request lasts one cycle");
        @(negedge clk);
    endtask

    task automatic finish_repair();
        @(negedge clk); fix_done = 1'b1;
        @(negedge clk); fix_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        push(1'b0, 0, "R1 reset state");
        @(negedge clk);

        // R8: merged verdict of the two checkers
        res_a = 8'h55; res_b = 8'h55; #1;
        direct_check(match, 1'b1, "R8 equal words match");
        res_b = 8'h54; #1;
        direct_check(match, 1'b0, "R8 differing words mismatch");
        @(negedge clk);

        run_window(6, 2'd0, 2'd0, 1'b0, 1'b0, "R3 six stays healthy");
        run_window(7, 2'd1, 2'd1, 1'b0, 1'b0, "R3 seven makes doubted");
        // R7 + R9: both qualify, A wins; fix_done at the close is ignored
        run_window(7, 2'd2, 2'd1, 1'b1, 1'b1, "R4 R7 A to mending B stays doubted");
        // R6: hold phase ignores valid samples
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            valid = 1'b1; res_a = 8'h0F; res_b = 8'hF0;
        end
        @(negedge clk);
        valid = 1'b0;
        @(posedge clk);
        push(1'b0, 0, "R6 R9 hold ignores samples");
        finish_repair();
        run_window(5, 2'd2, 2'd0, 1'b1, 1'b0, "R5 R4 A retained in mending B healthy");
        finish_repair();
        run_window(4, 2'd3, 2'd0, 1'b0, 1'b0, "R5 four restores A");
        run_window(7, 2'd1, 2'd1, 1'b0, 1'b0, "R3 restored falls to doubted");
        run_window(0, 2'd0, 2'd0, 1'b0, 1'b0, "R4 clean window back to healthy");

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule